// File: doc/BRIEF.md
# In-Order Pipeline Stall Controller

This block is the control path of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each stage holds a control slot made of a valid bit, a three-bit instruction class and a tag that identifies the instruction. Every cycle the controller decides which stages move forward and which stay frozen, and where empty slots (bubbles) are inserted. It does this from four completion inputs, each owned by an outside subsystem: barrier done, write buffer drained, long floating-point operation done and device ready.

Two stages can raise a stall. Execute holds long floating-point operations and device accesses. Memory holds the three barrier classes and the write-ordering barrier. A stalled stage keeps its slot and freezes everything toward fetch, while stages toward writeback keep draining. The instruction held in memory has already executed, so its release produces exactly one commit strobe and no second execution. A completion pulse that reaches a barrier while it is still in execute is remembered. That memory is dropped once the instruction leaves.

Top module: `pipe_stall_ctl`

## Requirements
- R1: After reset all five slots are empty: `stage_hold`=0, `stage_adv`=5'b11111, `stall`=0, `commit`=0, `ex_fire`=0 and `wb_valid`=0.
- R2: Classes 1 (full barrier), 2 (exception barrier) and 3 (trap barrier) stay in memory until `barrier_done` is seen, then reach writeback on the same edge that samples the pulse.
- R3: Class 4 (write barrier) stays in memory until `drain_done` is seen. `barrier_done`, `fp_done` and `dev_ready` do not release it.
- R4: Class 5 (long floating-point) stays in execute until `fp_done` is seen. Completion is re-tested every cycle.
- R5: Class 6 (device access) stays in execute until `dev_ready` is seen.
- R6: Bit i of `stage_hold` and `stage_adv` refers to stage i (0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback). A memory stall gives `stage_hold`=5'b01111 and an execute stall gives 5'b00111. `stage_adv` is the inverse of `stage_hold`, and `stall` is high when any hold bit is set.
- R7: Stages below a stalled stage keep draining. While memory holds, writeback receives a bubble. While execute holds, memory receives a bubble.
- R8: A slot fetched with `fetch_valid`=0 never raises a stall, whatever its class.
- R9: A stall is released only by the completion input that owns it. It never times out.
- R10: `commit` pulses, with `commit_tag`, in the cycle a valid slot leaves memory, and that slot is in writeback on the next cycle. `commit` and `ex_fire` each fire exactly once per instruction.
- R11: A completion pulse is stored by the memory slot if that slot waits for it. Otherwise it is stored by a waiting execute slot, so an early barrier pulse seen in execute is honoured. The stored flag is cleared when the slot moves on, so the next barrier waits for its own pulse.
- R12: Instructions reach writeback in fetch order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch slot holds an instruction (taken when `stage_adv[0]`) |
| fetch_class | input | 3 | Instruction class: 0/7 plain, 1-3 barriers, 4 write barrier, 5 long FP, 6 device |
| fetch_tag | input | TAG_W | Instruction identifier |
| barrier_done | input | 1 | Barrier completion pulse |
| drain_done | input | 1 | Write buffer drained pulse |
| fp_done | input | 1 | Long floating-point completion pulse |
| dev_ready | input | 1 | Device readiness pulse |
| stage_adv | output | 5 | Per-stage advance enable |
| stage_hold | output | 5 | Per-stage hold enable |
| ex_fire | output | 1 | Execute slot completes and leaves execute |
| commit | output | 1 | Register write of the memory slot commits |
| commit_tag | output | TAG_W | Tag of the committing slot |
| stall | output | 1 | Any stage is held |
| wb_valid | output | 1 | Writeback slot is valid |
| wb_tag | output | TAG_W | Tag in writeback |

## Verification
The hardest case to reach is a barrier pulse arriving while two barriers sit in adjacent stages. The pulse must go to the older one in memory, and the younger one in execute must neither take it nor keep a stale flag. The bench creates this by fetching two barriers back to back and timing single-cycle pulses by absolute edge number: one pulse lands while the first barrier is stalled in memory, and another lands before either barrier reaches memory. It then logs the edge at which each tag reaches writeback and compares it with the edge predicted by the requirements.

// File: rtl/pipe_stall_pkg.sv
package pipe_stall_pkg;
  localparam int NSTG  = 5;
  localparam int S_IF  = 0;
  localparam int S_ID  = 1;
  localparam int S_EX  = 2;
  localparam int S_MEM = 3;
  localparam int S_WB  = 4;

  typedef enum logic [2:0] {
    IC_PLAIN    = 3'd0,
    IC_FULL_BAR = 3'd1,
    IC_EXC_BAR  = 3'd2,
    IC_TRAP_BAR = 3'd3,
    IC_WR_BAR   = 3'd4,
    IC_FP_LONG  = 3'd5,
    IC_DEVICE   = 3'd6,
    IC_PLAIN2   = 3'd7
  } iclass_e;

  typedef struct packed {
    logic    valid;
    iclass_e cls;
    logic    done;   // completion seen for this slot
  } ctl_slot_t;

  function automatic logic wants_barrier(input iclass_e c);
    return (c == IC_FULL_BAR) || (c == IC_EXC_BAR) || (c == IC_TRAP_BAR);
  endfunction

  function automatic logic wants_drain(input iclass_e c);
    return c == IC_WR_BAR;
  endfunction

  function automatic logic wants_fp(input iclass_e c);
    return c == IC_FP_LONG;
  endfunction

  function automatic logic wants_dev(input iclass_e c);
    return c == IC_DEVICE;
  endfunction
endpackage

// File: rtl/pipe_stall_detect.sv
module pipe_stall_detect
  import pipe_stall_pkg::*;
(
  input  ctl_slot_t ex_slot,
  input  ctl_slot_t mem_slot,
  input  logic      barrier_done,
  input  logic      drain_done,
  input  logic      fp_done,
  input  logic      dev_ready,
  output logic      ex_stall,
  output logic      mem_stall,
  output logic      ex_done_nxt
);
  logic mem_needs_bar, mem_needs_drn, mem_evt;
  logic ex_evt, ex_multi;

  // R11: memory slot has first claim on a barrier/drain pulse
  assign mem_needs_bar = mem_slot.valid && wants_barrier(mem_slot.cls) && !mem_slot.done;
  assign mem_needs_drn = mem_slot.valid && wants_drain(mem_slot.cls) && !mem_slot.done;
  assign mem_evt = (mem_needs_bar && barrier_done) || (mem_needs_drn && drain_done);

  // R2, R3, R8: only a valid waiting slot stalls memory
  assign mem_stall = (mem_needs_bar || mem_needs_drn) && !mem_evt;

  assign ex_evt = ex_slot.valid && (
      (wants_barrier(ex_slot.cls) && barrier_done && !mem_needs_bar) ||
      (wants_drain(ex_slot.cls)   && drain_done   && !mem_needs_drn) ||
      (wants_fp(ex_slot.cls)      && fp_done) ||
      (wants_dev(ex_slot.cls)     && dev_ready));

  // R4, R5: long FP and device accesses wait in execute
  assign ex_multi    = wants_fp(ex_slot.cls) || wants_dev(ex_slot.cls);
  assign ex_stall    = ex_slot.valid && ex_multi && !(ex_slot.done || ex_evt);
  assign ex_done_nxt = ex_slot.done || ex_evt;
endmodule

// File: rtl/pipe_hold_chain.sv
module pipe_hold_chain
  import pipe_stall_pkg::*;
(
  input  logic [NSTG-1:0] stall_at,
  output logic [NSTG-1:0] hold_o,
  output logic [NSTG-1:0] adv_o
);
  // R6: a held stage freezes every stage toward fetch
  assign hold_o[NSTG-1] = stall_at[NSTG-1];
  genvar i;
  generate
    for (i = 0; i < NSTG - 1; i++) begin : g_chain
      assign hold_o[i] = stall_at[i] | hold_o[i+1];
    end
  endgenerate
  assign adv_o = ~hold_o;
endmodule

// File: rtl/pipe_slot_regs.sv
module pipe_slot_regs
  import pipe_stall_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fetch_valid,
  input  logic [2:0]                       fetch_class,
  input  logic [TAG_W-1:0]                 fetch_tag,
  input  logic [NSTG-1:0]                  hold,
  input  logic                             ex_done_nxt,
  output ctl_slot_t [NSTG-1:0]             slot_q,
  output logic [NSTG-1:0][TAG_W-1:0]       tag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      tag_q  <= '0;
    end else begin
      if (!hold[S_IF]) begin
        slot_q[S_IF].valid <= fetch_valid;
        slot_q[S_IF].cls   <= iclass_e'(fetch_class);
        slot_q[S_IF].done  <= 1'b0;
        tag_q[S_IF]        <= fetch_tag;
      end
      for (int s = 1; s < NSTG; s++) begin
        if (hold[s]) begin
          if (s == S_EX) slot_q[s].done <= ex_done_nxt;   // R11 latch while held
        end else if (hold[s-1]) begin
          slot_q[s].valid <= 1'b0;                        // R7 bubble below a stall
          slot_q[s].done  <= 1'b0;
        end else begin
          slot_q[s] <= slot_q[s-1];
          slot_q[s].done <= (s == S_MEM) ? ex_done_nxt : 1'b0;
          tag_q[s]  <= tag_q[s-1];
        end
      end
    end
  end

  // R6: memory slot unchanged while memory holds
  a_r6_mem_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hold[S_MEM] |=> (slot_q[S_MEM].valid == $past(slot_q[S_MEM].valid) &&
                     tag_q[S_MEM] == $past(tag_q[S_MEM])));
  // R6: decode frozen while execute holds
  a_r6_id_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold[S_EX] |=> (slot_q[S_ID].valid == $past(slot_q[S_ID].valid) &&
                    tag_q[S_ID] == $past(tag_q[S_ID])));
  // R7: writeback gets a bubble behind a memory hold
  a_r7_wb_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    hold[S_MEM] |=> !slot_q[S_WB].valid);
endmodule

// File: rtl/pipe_stall_ctl.sv
module pipe_stall_ctl
  import pipe_stall_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [2:0]       fetch_class,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic             barrier_done,
  input  logic             drain_done,
  input  logic             fp_done,
  input  logic             dev_ready,
  output logic [4:0]       stage_adv,
  output logic [4:0]       stage_hold,
  output logic             ex_fire,
  output logic             commit,
  output logic [TAG_W-1:0] commit_tag,
  output logic             stall,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  ctl_slot_t [NSTG-1:0]       slot_q;
  logic [NSTG-1:0][TAG_W-1:0] tag_q;
  logic [NSTG-1:0]            stall_at, hold, adv;
  logic                       ex_stall, mem_stall, ex_done_nxt;

  pipe_stall_detect u_detect (
    .ex_slot     (slot_q[S_EX]),
    .mem_slot    (slot_q[S_MEM]),
    .barrier_done(barrier_done),
    .drain_done  (drain_done),
    .fp_done     (fp_done),
    .dev_ready   (dev_ready),
    .ex_stall    (ex_stall),
    .mem_stall   (mem_stall),
    .ex_done_nxt (ex_done_nxt)
  );

  always_comb begin
    stall_at         = '0;
    stall_at[S_EX]   = ex_stall;
    stall_at[S_MEM]  = mem_stall;
  end

  pipe_hold_chain u_chain (
    .stall_at(stall_at),
    .hold_o  (hold),
    .adv_o   (adv)
  );

  pipe_slot_regs #(.TAG_W(TAG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_valid(fetch_valid),
    .fetch_class(fetch_class),
    .fetch_tag  (fetch_tag),
    .hold       (hold),
    .ex_done_nxt(ex_done_nxt),
    .slot_q     (slot_q),
    .tag_q      (tag_q)
  );

  assign stage_hold = hold;
  assign stage_adv  = adv;
  assign stall      = |hold;
  assign ex_fire    = slot_q[S_EX].valid && !hold[S_EX];
  assign commit     = slot_q[S_MEM].valid && !hold[S_MEM];  // R10
  assign commit_tag = tag_q[S_MEM];
  assign wb_valid   = slot_q[S_WB].valid;
  assign wb_tag     = tag_q[S_WB];

  // R9: only the owning pulse releases a memory stall
  a_r9_mem_owner: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |=> (mem_stall || barrier_done || drain_done));
  // R9: only the owning pulse releases an execute stall
  a_r9_ex_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ex_stall |=> (ex_stall || fp_done || dev_ready));
  // R10: a committed slot is in writeback next cycle
  a_r10_commit_to_wb: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (wb_valid && wb_tag == $past(commit_tag)));
endmodule

// File: tb/pipe_stall_ctl_bench.sv
`timescale 1ns/1ps
module pipe_stall_ctl_bench;
  localparam int TW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [2:0] fetch_class = 3'd0;
  logic [TW-1:0] fetch_tag = '0;
  logic barrier_done = 1'b0, drain_done = 1'b0, fp_done = 1'b0, dev_ready = 1'b0;
  logic [4:0] stage_adv, stage_hold;
  logic ex_fire, commit, stall, wb_valid;
  logic [TW-1:0] commit_tag, wb_tag;

  pipe_stall_ctl #(.TAG_W(TW)) u_pipe_stall_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_class(fetch_class),
    .fetch_tag(fetch_tag), .barrier_done(barrier_done), .drain_done(drain_done),
    .fp_done(fp_done), .dev_ready(dev_ready), .stage_adv(stage_adv),
    .stage_hold(stage_hold), .ex_fire(ex_fire), .commit(commit),
    .commit_tag(commit_tag), .stall(stall), .wb_valid(wb_valid), .wb_tag(wb_tag));

  always #10 clk = ~clk;  // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int bar_a = -1, bar_b = -1, drn_e = -1, fp_e = -1, dev_e = -1;
  int nlog = 0, ncommit = 0, nfire = 0;
  int log_cyc [16];
  int log_tag [16];

  // pulse sources: a pulse set for edge k is high in the cycle sampled at edge k
  initial forever begin
    @(negedge clk);
    barrier_done = (cyc + 1 == bar_a) || (cyc + 1 == bar_b);
    drain_done   = (cyc + 1 == drn_e);
    fp_done      = (cyc + 1 == fp_e);
    dev_ready    = (cyc + 1 == dev_e);
  end

  // writeback / commit monitor, stamped with the last edge number
  initial forever begin
    @(negedge clk); #3;
    if (rst_n) begin
      if (wb_valid && nlog < 16) begin log_cyc[nlog] = cyc; log_tag[nlog] = int'(wb_tag); nlog++; end
      if (commit) ncommit++;
      if (ex_fire) nfire++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic do_reset();
    fetch_valid = 0; rst_n = 0;
    bar_a = -1; bar_b = -1; drn_e = -1; fp_e = -1; dev_e = -1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    nlog = 0; ncommit = 0; nfire = 0;
  endtask

  task automatic issue(input logic [2:0] c, input int t, output int e0);
    @(negedge clk);
    fetch_valid = 1; fetch_class = c; fetch_tag = TW'(t);
    #1;
    while (!stage_adv[0]) begin @(negedge clk); #1; end
    e0 = cyc + 1;
  endtask

  task automatic idle();
    @(negedge clk); fetch_valid = 0; fetch_class = 3'd5;
  endtask

  task automatic wait_edge(input int e);
    while (cyc < e) @(negedge clk);
    #2;
  endtask

  task automatic chk_log(input int i, input int t, input int e, input string req);
    chk(nlog > i && log_tag[i] == t, req, (nlog > i) ? log_tag[i] : -1, t);
    chk(nlog > i && log_cyc[i] == e, req, (nlog > i) ? log_cyc[i] : -1, e);
  endtask

  // {class, pulse edge offset, expected writeback edge offset}
  localparam logic [10:0] ROWS [10] = '{
    {3'd0, 4'd0, 4'd4},   // R10 plain
    {3'd5, 4'd3, 4'd4},   // R4 FP done on first EX cycle
    {3'd5, 4'd6, 4'd7},   // R4 FP long wait
    {3'd6, 4'd5, 4'd6},   // R5 device backpressure
    {3'd1, 4'd3, 4'd4},   // R11 early barrier pulse in EX
    {3'd1, 4'd7, 4'd7},   // R2 full barrier
    {3'd2, 4'd4, 4'd4},   // R2 exception barrier, pulse on MEM entry
    {3'd3, 4'd6, 4'd6},   // R2 trap barrier
    {3'd4, 4'd5, 4'd5},   // R3 write barrier
    {3'd4, 4'd3, 4'd4}    // R11 early drain pulse
  };

  initial begin
    int e0, e1;
    bit bad;
    // R1 reset state
    do_reset();
    #2;
    chk(stage_hold == 5'b0, "R1 hold", int'(stage_hold), 0);
    chk(stage_adv == 5'b11111, "R1 adv", int'(stage_adv), 31);
    chk(!stall && !commit && !ex_fire && !wb_valid, "R1 idle outputs",
        int'({stall, commit, ex_fire, wb_valid}), 0);

    for (int r = 0; r < 10; r++) begin
      logic [2:0] c; int k, ex;
      c = ROWS[r][10:8]; k = int'(ROWS[r][7:4]); ex = int'(ROWS[r][3:0]);
      do_reset();
      issue(c, r + 1, e0);
      case (c)
        3'd1, 3'd2, 3'd3: bar_a = e0 + k;
        3'd4: drn_e = e0 + k;
        3'd5: fp_e = e0 + k;
        3'd6: dev_e = e0 + k;
        default: ;
      endcase
      idle();
      wait_edge(e0 + ex - 1);
      chk(commit && commit_tag == TW'(r + 1), "R10 commit cycle", int'(commit), 1);
      wait_edge(e0 + 14);
      chk(nlog == 1, "R12 single retire", nlog, 1);
      chk_log(0, r + 1, e0 + ex, (c == 3'd4) ? "R3 retire edge" :
              (c == 3'd5) ? "R4 retire edge" : (c == 3'd6) ? "R5 retire edge" : "R2 retire edge");
      chk(ncommit == 1 && nfire == 1, "R10 once each", ncommit * 10 + nfire, 11);
    end

    // R6 R7 R12: memory stall freezes upstream, drains downstream
    do_reset();
    issue(3'd0, 1, e0); issue(3'd1, 2, e1); issue(3'd0, 3, e1); issue(3'd0, 4, e1);
    bar_a = e0 + 9;
    idle();
    wait_edge(e0 + 6);
    chk(stage_hold == 5'b01111, "R6 mem hold pattern", int'(stage_hold), 15);
    chk(stage_adv == 5'b10000 && stall, "R6 adv/stall", int'(stage_adv), 16);
    chk(!wb_valid, "R7 wb bubble", int'(wb_valid), 0);
    wait_edge(e0 + 16);
    chk(nlog == 4 && ncommit == 4, "R12 four retire", nlog, 4);
    chk_log(0, 1, e0 + 4, "R7 older drains");
    chk_log(1, 2, e0 + 9, "R9 owner release");
    chk_log(2, 3, e0 + 10, "R12 order");
    chk_log(3, 4, e0 + 11, "R12 order");

    // R6 R7: execute stall
    do_reset();
    issue(3'd5, 8, e0); issue(3'd0, 9, e1);
    fp_e = e0 + 6;
    idle();
    wait_edge(e0 + 3);
    chk(stage_hold == 5'b00111 && stall, "R6 ex hold pattern", int'(stage_hold), 7);
    chk(!commit, "R7 mem bubble", int'(commit), 0);
    wait_edge(e0 + 14);
    chk_log(0, 8, e0 + 7, "R4 fp release");
    chk_log(1, 9, e0 + 8, "R12 order");

    // R8: invalid slots with stalling classes never stall
    do_reset();
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); fetch_valid = 0; fetch_class = (i % 2) ? 3'd5 : 3'd1; #2;
      if (stall) bad = 1;
    end
    chk(!bad && nlog == 0, "R8 bubble no stall", int'(bad), 0);

    // R11: early pulse latched, then cleared for the next barrier
    do_reset();
    issue(3'd1, 5, e0); issue(3'd1, 6, e1);
    bar_a = e0 + 3; bar_b = e0 + 8;
    idle();
    wait_edge(e0 + 5);
    chk(stall, "R11 latch cleared", int'(stall), 1);
    wait_edge(e0 + 14);
    chk_log(0, 5, e0 + 4, "R11 early pulse");
    chk_log(1, 6, e0 + 8, "R11 own pulse");

    // R11: memory slot has priority on a shared pulse
    do_reset();
    issue(3'd1, 10, e0); issue(3'd2, 11, e1);
    bar_a = e0 + 5; bar_b = e0 + 9;
    idle();
    wait_edge(e0 + 16);
    chk_log(0, 10, e0 + 5, "R11 mem priority");
    chk_log(1, 11, e0 + 9, "R11 ex not captured");

    // R3 R9: foreign pulses do not release a write barrier
    do_reset();
    issue(3'd4, 7, e0);
    bar_a = e0 + 4; fp_e = e0 + 4; dev_e = e0 + 5; drn_e = e0 + 7;
    idle();
    wait_edge(e0 + 5);
    chk(stall, "R3 foreign pulse ignored", int'(stall), 1);
    wait_edge(e0 + 12);
    chk(nlog == 1, "R3 single retire", nlog, 1);
    chk_log(0, 7, e0 + 7, "R3 drain release");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule